// File: doc/BRIEF.md
# Performance Monitor Control Register File

This block is the system-register file that sits beside a processor's performance monitor. Each access names a register with a 4-bit minor register number and a 3-bit selector. It carries a read or write flag, write data, and the privilege level of the code making the access. The block holds the monitor's control word, count-enable state, overflow flags, event-type selection, user-access enable and interrupt-enable state. The counters themselves are not implemented. Their registers read as zero and discard writes.

Every access is checked against one of three privilege classes. Interrupt-enable registers are reserved for privileged code. The user-enable register can be read by unprivileged code but not written by it. All other monitor registers are open to unprivileged code only while the user-enable bit held inside this block is set. An access that is not allowed, or that names no register, raises a one-cycle undefined-instruction flag and leaves all state as it was. External counters report overflows on `ovf_set_i`; software clears the flags by writing ones.

Top module: `pmu_regfile`

## Requirements
- R1: After reset every stored register reads as zero and `undef_o` and `rdata_o` are low.
- R2: The control register (crm 12, sel 0) takes written bits 0, 3, 4 and 5 (mask 0x39). All its other bits read as zero.
- R3: Count enable has a set address (crm 12, sel 1) and a clear address (crm 12, sel 2), and both read the same value. A written 1 in bit 31 sets or clears the stored bit 31. All other written bits are ignored.
- R4: The overflow flags (crm 12, sel 3) are write-one-to-clear. Each bit of `ovf_set_i` sets its flag. When a set and a clear hit the same bit in the same cycle, the set wins.
- R5: The event-type register (crm 13, sel 1) stores the low 8 bits of the written value. Its upper bits read as zero.
- R6: The user-enable register (crm 14, sel 0) stores bit 0 only. Unprivileged code may read it. An unprivileged write raises undef.
- R7: Interrupt enable has a set address (crm 14, sel 1) and a clear address (crm 14, sel 2). It behaves like count enable, restricted to bit 31, and any unprivileged access to it raises undef.
- R8: Any other mapped register accessed unprivileged raises undef while user-enable is 0 and is accessible while user-enable is 1.
- R9: Software increment (crm 12, sel 4), counter select (crm 12, sel 5), cycle count (crm 13, sel 0) and event count (crm 13, sel 2) read as zero and ignore writes.
- R10: Any unmapped crm/sel combination raises undef and changes no register.
- R11: A request at a clock edge produces `rdata_o` and `undef_o` registered after that edge for one cycle. An undef access modifies nothing and returns zero read data. A write returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| crm_i | input | 4 | Minor register number |
| sel_i | input | 3 | Register selector |
| priv_i | input | 1 | 1 = privileged access |
| wdata_i | input | 32 | Write data |
| ovf_set_i | input | 32 | Overflow flag set pulses from counters |
| rdata_o | output | 32 | Read data, one cycle after the request |
| undef_o | output | 1 | Undefined-access pulse, one cycle after the request |

## Verification
Corrupted stored state shows up at the next read of the affected register, one cycle after that read is requested. A wrong user-enable bit shows up at once as an undef pulse, or a missing one, on the first unprivileged access to a gated register. The bench therefore reads back after every write and sweeps each privilege class with user-enable both clear and set. It also writes through illegal accesses and then reads the targets back from privileged level, to show they were untouched.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [3:0] {
    ID_CTRL, ID_CEN_SET, ID_CEN_CLR, ID_OVF, ID_SWINC, ID_CSEL,
    ID_CYC, ID_EVT, ID_EVCNT, ID_UEN, ID_IEN_SET, ID_IEN_CLR, ID_NONE
  } reg_id_e;

  typedef enum logic [1:0] {
    CLS_GATED,     // needs priv or user-enable
    CLS_USER_RO,   // unpriv read only
    CLS_PRIV_ONLY,
    CLS_UNMAPPED
  } acc_cls_e;
endpackage

// File: rtl/pmu_decode.sv
module pmu_decode import pmu_pkg::*; #(
  parameter int CRM_W = 4,
  parameter int SEL_W = 3
) (
  input  logic [CRM_W-1:0] crm_i,
  input  logic [SEL_W-1:0] sel_i,
  output reg_id_e          id_o,
  output acc_cls_e         cls_o
);
  always_comb begin
    id_o = ID_NONE;
    unique case (crm_i)
      CRM_W'(12): case (sel_i)
        SEL_W'(0): id_o = ID_CTRL;
        SEL_W'(1): id_o = ID_CEN_SET;
        SEL_W'(2): id_o = ID_CEN_CLR;
        SEL_W'(3): id_o = ID_OVF;
        SEL_W'(4): id_o = ID_SWINC;
        SEL_W'(5): id_o = ID_CSEL;
        default:   id_o = ID_NONE;
      endcase
      CRM_W'(13): case (sel_i)
        SEL_W'(0): id_o = ID_CYC;
        SEL_W'(1): id_o = ID_EVT;
        SEL_W'(2): id_o = ID_EVCNT;
        default:   id_o = ID_NONE;
      endcase
      CRM_W'(14): case (sel_i)
        SEL_W'(0): id_o = ID_UEN;
        SEL_W'(1): id_o = ID_IEN_SET;
        SEL_W'(2): id_o = ID_IEN_CLR;
        default:   id_o = ID_NONE;
      endcase
      default: id_o = ID_NONE;
    endcase
  end

  always_comb begin
    unique case (id_o)
      ID_NONE:                cls_o = CLS_UNMAPPED;
      ID_UEN:                 cls_o = CLS_USER_RO;
      ID_IEN_SET, ID_IEN_CLR: cls_o = CLS_PRIV_ONLY;
      default:                cls_o = CLS_GATED;
    endcase
  end
endmodule

// File: rtl/pmu_access.sv
module pmu_access import pmu_pkg::*; (
  input  acc_cls_e cls_i,
  input  logic     priv_i,
  input  logic     we_i,
  input  logic     uen_i,
  output logic     illegal_o
);
  always_comb begin
    unique case (cls_i)
      CLS_UNMAPPED:  illegal_o = 1'b1;
      CLS_PRIV_ONLY: illegal_o = !priv_i;
      CLS_USER_RO:   illegal_o = !priv_i && we_i;
      default:       illegal_o = !priv_i && !uen_i;
    endcase
  end
endmodule

// File: rtl/pmu_state.sv
module pmu_state import pmu_pkg::*; #(
  parameter int          DATA_W    = 32,
  parameter int          EVT_W     = 8,
  parameter int          EN_BIT    = 31,
  parameter logic [31:0] CTRL_MASK = 32'h39
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,      // qualified legal write
  input  reg_id_e           id_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ovf_set_i,
  output logic [DATA_W-1:0] rd_val_o,
  output logic              uen_o
);
  localparam logic [DATA_W-1:0] CMASK = CTRL_MASK[DATA_W-1:0];

  logic [DATA_W-1:0] ctrl_q, ovf_q, ovf_clr;
  logic [EVT_W-1:0]  evt_q;
  logic              cen_q, ien_q, uen_q;

  assign ovf_clr = (wr_i && id_i == ID_OVF) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovf_q  <= '0;
      evt_q  <= '0;
      cen_q  <= 1'b0;
      ien_q  <= 1'b0;
      uen_q  <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_set_i;  // set beats clear
      if (wr_i) begin
        unique case (id_i)
          ID_CTRL:    ctrl_q <= (ctrl_q & ~CMASK) | (wdata_i & CMASK);
          ID_CEN_SET: cen_q  <= cen_q | wdata_i[EN_BIT];
          ID_CEN_CLR: cen_q  <= cen_q & ~wdata_i[EN_BIT];
          ID_EVT:     evt_q  <= wdata_i[EVT_W-1:0];
          ID_UEN:     uen_q  <= wdata_i[0];
          ID_IEN_SET: ien_q  <= ien_q | wdata_i[EN_BIT];
          ID_IEN_CLR: ien_q  <= ien_q & ~wdata_i[EN_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val_o = '0;
    unique case (id_i)
      ID_CTRL:                rd_val_o = ctrl_q;
      ID_CEN_SET, ID_CEN_CLR: rd_val_o[EN_BIT] = cen_q;
      ID_OVF:                 rd_val_o = ovf_q;
      ID_EVT:                 rd_val_o[EVT_W-1:0] = evt_q;
      ID_UEN:                 rd_val_o[0] = uen_q;
      ID_IEN_SET, ID_IEN_CLR: rd_val_o[EN_BIT] = ien_q;
      default:                rd_val_o = '0;
    endcase
  end

  assign uen_o = uen_q;

  assert_ctrl_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && id_i == ID_CTRL) |=> $stable(ctrl_q & ~CMASK));
  assert_ovf_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_set_i != '0) |=> ((ovf_q & $past(ovf_set_i)) == $past(ovf_set_i)));
endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile import pmu_pkg::*; #(
  parameter int          DATA_W    = 32,
  parameter int          CRM_W     = 4,
  parameter int          SEL_W     = 3,
  parameter int          EVT_W     = 8,
  parameter int          EN_BIT    = 31,
  parameter logic [31:0] CTRL_MASK = 32'h39
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [CRM_W-1:0]  crm_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              priv_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ovf_set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              undef_o
);
  reg_id_e           id;
  acc_cls_e          cls;
  logic              illegal, uen, wr_ok;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              undef_q;

  pmu_decode #(.CRM_W(CRM_W), .SEL_W(SEL_W)) i_decode (
    .crm_i(crm_i), .sel_i(sel_i), .id_o(id), .cls_o(cls));

  pmu_access i_access (
    .cls_i(cls), .priv_i(priv_i), .we_i(we_i), .uen_i(uen), .illegal_o(illegal));

  assign wr_ok = req_i && we_i && !illegal;

  pmu_state #(.DATA_W(DATA_W), .EVT_W(EVT_W), .EN_BIT(EN_BIT), .CTRL_MASK(CTRL_MASK)) i_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ok), .id_i(id), .wdata_i(wdata_i),
    .ovf_set_i(ovf_set_i), .rd_val_o(rd_val), .uen_o(uen));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      undef_q <= 1'b0;
    end else begin
      undef_q <= req_i && illegal;
      rdata_q <= (req_i && !we_i && !illegal) ? rd_val : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign undef_o = undef_q;

  assert_undef_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> rdata_o == '0);
  assert_unmapped_undef_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cls == CLS_UNMAPPED) |=> undef_o);
  assert_priv_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && cls == CLS_PRIV_ONLY) |=> undef_o);
  assert_uen_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i && cls == CLS_GATED && !uen) |=> undef_o);
  assert_bad_write_keeps_uen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && illegal) |=> $stable(uen));
endmodule

// File: tb/test_pmu_regfile.sv
module test_pmu_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, priv = 1'b0;
  logic [3:0]  crm = '0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0, ovf_set = '0;
  logic [31:0] rdata;
  logic        undef;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pmu_regfile i_pmu_regfile (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .crm_i(crm), .sel_i(sel),
    .priv_i(priv), .wdata_i(wdata), .ovf_set_i(ovf_set), .rdata_o(rdata), .undef_o(undef));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; result sampled after the edge that registers it
  task automatic acc(input logic w, input logic p, input int c, input int s,
                     input logic [31:0] d, output logic [31:0] rd, output logic ud);
    @(negedge clk);
    req = 1'b1; we = w; priv = p; crm = 4'(c); sel = 3'(s); wdata = d;
    @(posedge clk); #1;
    rd = rdata; ud = undef;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic p, input int c, input int s,
                        input logic [31:0] exp_d, input logic exp_u);
    logic [31:0] d; logic u;
    acc(1'b0, p, c, s, 32'h0, d, u);
    check({tag, " data"}, d, exp_d);
    check({tag, " undef"}, {31'b0, u}, {31'b0, exp_u});
  endtask

  task automatic wr_chk(input string tag, input logic p, input int c, input int s,
                        input logic [31:0] wd, input logic exp_u);
    logic [31:0] d; logic u;
    acc(1'b1, p, c, s, wd, d, u);
    check({tag, " wdata"}, d, 32'h0);
    check({tag, " undef"}, {31'b0, u}, {31'b0, exp_u});
  endtask

  task automatic t_reset;
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 undef after reset", {31'b0, undef}, 32'h0);
    rd_chk("R1 ctrl", 1, 12, 0, 0, 0);
    rd_chk("R1 cen", 1, 12, 1, 0, 0);
    rd_chk("R1 ovf", 1, 12, 3, 0, 0);
    rd_chk("R1 evt", 1, 13, 1, 0, 0);
    rd_chk("R1 uen", 1, 14, 0, 0, 0);
    rd_chk("R1 ien", 1, 14, 1, 0, 0);
  endtask

  task automatic t_ctrl;
    wr_chk("R2 ctrl all ones", 1, 12, 0, 32'hFFFF_FFFF, 0);
    rd_chk("R2 ctrl masked", 1, 12, 0, 32'h39, 0);
    wr_chk("R2 ctrl partial", 1, 12, 0, 32'h0000_0011, 0);
    rd_chk("R2 ctrl partial", 1, 12, 0, 32'h11, 0);
  endtask

  task automatic t_cen;
    wr_chk("R3 cen set low bits", 1, 12, 1, 32'h7FFF_FFFF, 0);
    rd_chk("R3 cen ignored", 1, 12, 1, 0, 0);
    wr_chk("R3 cen set", 1, 12, 1, 32'h8000_0000, 0);
    rd_chk("R3 cen via clr addr", 1, 12, 2, 32'h8000_0000, 0);
    wr_chk("R3 cen clr zero", 1, 12, 2, 32'h0, 0);
    rd_chk("R3 cen kept", 1, 12, 1, 32'h8000_0000, 0);
    wr_chk("R3 cen clr", 1, 12, 2, 32'hFFFF_FFFF, 0);
    rd_chk("R3 cen cleared", 1, 12, 1, 0, 0);
  endtask

  task automatic t_ovf;
    logic [31:0] d; logic u;
    @(negedge clk); ovf_set = 32'h8000_00F1;
    @(negedge clk); ovf_set = 32'h0;
    rd_chk("R4 ovf raised", 1, 12, 3, 32'h8000_00F1, 0);
    wr_chk("R4 ovf w1c", 1, 12, 3, 32'h0000_0031, 0);
    rd_chk("R4 ovf after w1c", 1, 12, 3, 32'h8000_00C0, 0);
    // clear bit 7 while setting it in the same cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; priv = 1'b1; crm = 4'd12; sel = 3'd3;
    wdata = 32'h8000_0080; ovf_set = 32'h0000_0080;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; ovf_set = 32'h0;
    acc(1'b0, 1, 12, 3, 0, d, u);
    check("R4 set beats clear", d, 32'h0000_00C0);
  endtask

  task automatic t_evt;
    wr_chk("R5 evt write", 1, 13, 1, 32'hDEAD_BEA5, 0);
    rd_chk("R5 evt low byte", 1, 13, 1, 32'hA5, 0);
  endtask

  task automatic t_zero_regs;
    wr_chk("R9 swinc", 1, 12, 4, 32'hFFFF_FFFF, 0);
    rd_chk("R9 swinc", 1, 12, 4, 0, 0);
    wr_chk("R9 csel", 1, 12, 5, 32'hFFFF_FFFF, 0);
    rd_chk("R9 csel", 1, 12, 5, 0, 0);
    wr_chk("R9 cyc", 1, 13, 0, 32'h1234_5678, 0);
    rd_chk("R9 cyc", 1, 13, 0, 0, 0);
    wr_chk("R9 evcnt", 1, 13, 2, 32'h1234_5678, 0);
    rd_chk("R9 evcnt", 1, 13, 2, 0, 0);
  endtask

  task automatic t_unmapped;
    wr_chk("R10 crm12 sel6", 1, 12, 6, 32'hFFFF_FFFF, 1);
    rd_chk("R10 crm13 sel3", 1, 13, 3, 0, 1);
    rd_chk("R10 crm14 sel7", 1, 14, 7, 0, 1);
    wr_chk("R10 crm9", 1, 9, 0, 32'hFFFF_FFFF, 1);
    rd_chk("R10 ctrl untouched", 1, 12, 0, 32'h11, 0);
    rd_chk("R10 uen untouched", 1, 14, 0, 0, 0);
  endtask

  task automatic t_user_gate;
    // uen = 0: gated registers undef
    rd_chk("R8 unpriv ctrl read", 0, 12, 0, 0, 1);
    wr_chk("R8 unpriv evt write", 0, 13, 1, 32'h3C, 1);
    rd_chk("R11 evt untouched", 1, 13, 1, 32'hA5, 0);
    rd_chk("R6 unpriv uen read", 0, 14, 0, 0, 0);
    wr_chk("R6 unpriv uen write", 0, 14, 0, 32'h1, 1);
    rd_chk("R6 uen still 0", 1, 14, 0, 0, 0);
    wr_chk("R6 uen set", 1, 14, 0, 32'hFFFF_FFFF, 0);
    rd_chk("R6 uen bit0 only", 0, 14, 0, 32'h1, 0);
    // uen = 1: gated registers open
    rd_chk("R8 unpriv ctrl open", 0, 12, 0, 32'h11, 0);
    wr_chk("R8 unpriv evt open", 0, 13, 1, 32'h3C, 0);
    rd_chk("R8 evt written", 0, 13, 1, 32'h3C, 0);
    wr_chk("R6 unpriv uen clr", 0, 14, 0, 32'h0, 1);
    rd_chk("R6 uen still 1", 1, 14, 0, 32'h1, 0);
  endtask

  task automatic t_ien;
    wr_chk("R7 unpriv ien set", 0, 14, 1, 32'h8000_0000, 1);
    rd_chk("R7 unpriv ien read", 0, 14, 2, 0, 1);
    rd_chk("R7 ien untouched", 1, 14, 1, 0, 0);
    wr_chk("R7 ien set", 1, 14, 1, 32'hFFFF_FFFF, 0);
    rd_chk("R7 ien bit31", 1, 14, 2, 32'h8000_0000, 0);
    wr_chk("R7 unpriv ien clr", 0, 14, 2, 32'h8000_0000, 1);
    rd_chk("R7 ien kept", 1, 14, 1, 32'h8000_0000, 0);
    wr_chk("R7 ien clr", 1, 14, 2, 32'h8000_0000, 0);
    rd_chk("R7 ien cleared", 1, 14, 1, 0, 0);
  endtask

  task automatic t_pulse;
    logic [31:0] d; logic u;
    acc(1'b0, 1, 12, 7, 0, d, u);
    check("R11 undef raised", {31'b0, u}, 32'h1);
    @(posedge clk); #1;
    check("R11 undef one cycle", {31'b0, undef}, 32'h0);
    check("R11 rdata idle zero", rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_cen();
    t_ovf();
    t_evt();
    t_zero_regs();
    t_unmapped();
    t_user_gate();
    t_ien();
    t_pulse();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule